// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver with Status Handshake

This block is the receive-only slave side of a two-wire serial bus (clock line and data line, both open-drain). It watches the synchronised bus lines for a START condition. It then shifts in a 7-bit address and a direction bit, and checks them against a programmed own address. It can also check them against the general call address, zero. On a write-direction match it pulls the data line low for the acknowledge bit. It then raises an interrupt flag, reports an 8-bit status code, and stretches the clock line low until the host has handled the event.

Each following data byte is acknowledged or refused. The choice uses the acknowledge-enable value that the host supplies in the same write that clears the flag. Each byte is latched into a data register when the flag rises. A separate input strobe marks an arbitration loss elsewhere on the chip. The next own-address acceptance after that strobe then reports a distinct status code. The host uses a plain register port with a write strobe, a 2-bit register offset and a combinational read.

Register offsets:
- Offset 0 is control: bit 7 is the flag (write 1 to clear), bit 6 is acknowledge-enable, and bit 0 is block enable.
- Offset 1 holds the own address in bits 7..1 and the general-call enable in bit 0.
- Offset 2 is status, read only.
- Offset 3 is received data, read only.

Top module: `tws_slave_rx`

## Requirements
- R1: When the byte after START carries the own address (offset 1 bits 7..1) with direction bit 0, and enable (bit 0) and acknowledge-enable (bit 6) of offset 0 are both 1, the block drives the data line low during the ninth clock. It then sets the flag (offset 0 bit 7, also the irq_o output), reports status 0x60 at offset 2, and shows the address byte at offset 3.
- R2: The address byte 0x00 is acknowledged with status 0x70 only while offset 1 bit 0 is 1. While that bit is 0, the byte draws no acknowledge and no flag.
- R3: An own address with direction bit 1, or any other non-matching address byte, draws no acknowledge and no flag.
- R4: While offset 0 bit 6 is 0, neither the own address nor the general call is acknowledged. After the bit is set again, the next START with a matching address is acknowledged.
- R5: After a one-cycle pulse on arb_lost_i, the next accepted own-address write reports 0x68 instead of 0x60. The acceptance after that reports 0x60 again.
- R6: Each data byte is acknowledged when bit 6 of the word that cleared the previous flag was 1, and refused when it was 0. The resulting status is 0x80 or 0x88 for own-address transfers, and 0x90 or 0x98 for general-call transfers. The data byte appears at offset 3. Once the flag of a refused byte is cleared, the block is no longer addressed and refuses further bytes without raising the flag.
- R7: A STOP or a repeated START while addressed sets the flag with status 0xA0 and leaves the data register unchanged. After a repeated START, the address that follows is decoded anew.
- R8: While the flag is set and the bus clock line has been seen low, the block holds the clock line low. The flag is cleared by writing 1 to offset 0 bit 7, and the clock line is released within 3 cycles of that write.
- R9: After reset the flag is 0, nothing drives the bus, and offset 2 reads 0xF8. Offset 2 reads 0xF8 whenever the flag is 0.
- R10: While offset 0 bit 0 is 0, the block never drives either bus line and raises no flag.
- R11: The data register keeps its value for as long as the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_low_o | output | 1 | 1 pulls the bus clock line low (stretch) |
| sda_low_o | output | 1 | 1 pulls the bus data line low (acknowledge) |
| arb_lost_i | input | 1 | One-cycle strobe: arbitration was lost while acting as master |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | 2 | Host register offset |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for reg_addr_i |
| irq_o | output | 1 | Interrupt flag |

## Verification
The flag-clear handshake and the acknowledge decision for the next byte fall in the same cycle. One host write clears the flag and also changes acknowledge-enable, so the engine must take the new bit from the write word, not from the register that updates on the same edge. The bench provokes this by clearing a data-byte flag with acknowledge-enable written to 0 while the register still holds 1. It judges the outcome by the level the bus master samples in the next ninth clock, and by the 0x88 status that the scoreboard expects.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int REG_AW = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_HOLD
  } rx_state_e;

  localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] RA_OWN  = 2'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd2;
  localparam logic [REG_AW-1:0] RA_DATA = 2'd3;

  localparam int CB_FLAG = 7;
  localparam int CB_ACK  = 6;
  localparam int CB_EN   = 0;

  localparam logic [7:0] SC_OWN_W    = 8'h60;
  localparam logic [7:0] SC_ARB_W    = 8'h68;
  localparam logic [7:0] SC_GC_W     = 8'h70;
  localparam logic [7:0] SC_OWN_ACK  = 8'h80;
  localparam logic [7:0] SC_OWN_NACK = 8'h88;
  localparam logic [7:0] SC_GC_ACK   = 8'h90;
  localparam logic [7:0] SC_GC_NACK  = 8'h98;
  localparam logic [7:0] SC_STOP     = 8'hA0;
  localparam logic [7:0] SC_NONE     = 8'hF8;

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_pipe_q;
  logic [LAST:0] sda_pipe_q;
  logic          scl_d_q;
  logic          sda_d_q;

  // Both lines idle high, so the chains reset to ones.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe_q[g] <= 1'b1;
          sda_pipe_q[g] <= 1'b1;
        end else begin
          scl_pipe_q[g] <= (g == 0) ? scl_i : scl_pipe_q[(g == 0) ? 0 : g - 1];
          sda_pipe_q[g] <= (g == 0) ? sda_i : sda_pipe_q[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_pipe_q[LAST];
      sda_d_q <= sda_pipe_q[LAST];
    end
  end

  always_comb begin
    scl_s     = scl_pipe_q[LAST];
    sda_s     = sda_pipe_q[LAST];
    scl_rise  = scl_s & ~scl_d_q;
    scl_fall  = ~scl_s & scl_d_q;
    // A data edge counts as a condition only with the clock high on both samples.
    start_det = scl_s & scl_d_q & sda_d_q & ~sda_s;
    stop_det  = scl_s & scl_d_q & ~sda_d_q & sda_s;
  end

endmodule

// File: rtl/tws_host_regs.sv
module tws_host_regs
  import tws_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              raise,
  input  logic [7:0]        raise_code,
  input  logic              raise_latch,
  input  logic [DW-1:0]     rx_byte,
  output logic              en,
  output logic              ack_en,
  output logic [DW-2:0]     own_addr,
  output logic              gc_en,
  output logic              flag,
  output logic              clr_pulse,
  output logic              ack_at_clr,
  output logic [DW-1:0]     rdata
);

  logic          en_q,   en_n;
  logic          ack_q,  ack_n;
  logic [DW-1:0] own_q,  own_n;
  logic          flag_q, flag_n;
  logic [7:0]    stat_q, stat_n;
  logic [DW-1:0] data_q, data_n;
  logic          wr_ctrl, wr_own;

  always_comb begin
    wr_ctrl    = wr_en && (addr == RA_CTRL);
    wr_own     = wr_en && (addr == RA_OWN);
    clr_pulse  = wr_ctrl && wdata[CB_FLAG] && flag_q;
    ack_at_clr = wdata[CB_ACK];

    en_n   = wr_ctrl ? wdata[CB_EN]  : en_q;
    ack_n  = wr_ctrl ? wdata[CB_ACK] : ack_q;
    own_n  = wr_own  ? wdata         : own_q;
    stat_n = raise   ? raise_code    : stat_q;
    data_n = (raise && raise_latch) ? rx_byte : data_q;
    if (raise)          flag_n = 1'b1;
    else if (clr_pulse) flag_n = 1'b0;
    else                flag_n = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ack_q  <= 1'b0;
      own_q  <= '0;
      flag_q <= 1'b0;
      stat_q <= SC_NONE;
      data_q <= '0;
    end else begin
      en_q   <= en_n;
      ack_q  <= ack_n;
      own_q  <= own_n;
      flag_q <= flag_n;
      stat_q <= stat_n;
      data_q <= data_n;
    end
  end

  always_comb begin
    en       = en_q;
    ack_en   = ack_q;
    own_addr = own_q[DW-1:1];
    gc_en    = own_q[0];
    flag     = flag_q;
    rdata    = '0;
    unique case (addr)
      RA_CTRL: begin
        rdata[CB_FLAG] = flag_q;
        rdata[CB_ACK]  = ack_q;
        rdata[CB_EN]   = en_q;
      end
      RA_OWN:  rdata = own_q;
      RA_STAT: rdata = flag_q ? stat_q : SC_NONE;
      default: rdata = data_q;
    endcase
  end

  // R1: a reported event shows up on the flag one cycle later.
  a_r1_raise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> flag_q);

  // R8: a clear write without a concurrent event drops the flag.
  a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !raise) |=> !flag_q);

  // R11: the data register is frozen while the flag stays set.
  a_r11_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && $past(flag_q)) |-> $stable(data_q));

endmodule

// File: rtl/tws_rx_engine.sv
module tws_rx_engine
  import tws_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ack_en,
  input  logic [DW-2:0] own_addr,
  input  logic          gc_en,
  input  logic          arb_lost,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          flag,
  input  logic          clr_pulse,
  input  logic          ack_at_clr,
  output logic          raise,
  output logic [7:0]    raise_code,
  output logic          raise_latch,
  output logic [DW-1:0] rx_byte,
  output logic          sda_low,
  output logic          scl_low
);

  localparam int CW = $clog2(DW + 1);

  rx_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          match_q, match_n;
  logic          gc_q, gc_n;
  logic          ack_next_q, ack_next_n;
  logic          nack_q, nack_n;
  logic          arb_q, arb_n;
  logic          hold_q, hold_n;

  logic [DW-1:0] byte_in;
  logic          own_hit, gc_hit, addressed, last_bit, full;

  always_comb begin
    byte_in   = {sh_q[DW-2:0], sda_s};
    own_hit   = (byte_in[DW-1:1] == own_addr) && !byte_in[0];
    gc_hit    = gc_en && (byte_in == '0);
    addressed = (state_q == ST_DATA) || (state_q == ST_DACK);
    last_bit  = (cnt_q == CW'(DW - 1));
    full      = (cnt_q == CW'(DW));
  end

  always_comb begin
    state_n     = state_q;
    cnt_n       = cnt_q;
    sh_n        = sh_q;
    match_n     = match_q;
    gc_n        = gc_q;
    ack_next_n  = ack_next_q;
    nack_n      = nack_q;
    arb_n       = arb_q | arb_lost;
    hold_n      = 1'b0;
    raise       = 1'b0;
    raise_code  = SC_NONE;
    raise_latch = 1'b0;

    if (!en) begin
      state_n = ST_IDLE;
    end else begin
      // Grab the clock only once the bus has already brought it low.
      hold_n = flag && (hold_q || !scl_s);
      if (start_det) begin
        if (addressed) begin
          raise      = 1'b1;
          raise_code = SC_STOP;
        end
        state_n = ST_ADDR;
        cnt_n   = '0;
      end else if (stop_det) begin
        if (addressed) begin
          raise      = 1'b1;
          raise_code = SC_STOP;
        end
        state_n = ST_IDLE;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise && !full) begin
              sh_n  = byte_in;
              cnt_n = cnt_q + CW'(1);
              if (last_bit) begin
                match_n = ack_en && (own_hit || gc_hit);
                gc_n    = gc_hit;
              end
            end else if (scl_fall && full) begin
              state_n = match_q ? ST_AACK : ST_IDLE;
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              raise       = 1'b1;
              raise_latch = 1'b1;
              nack_n      = 1'b0;
              state_n     = ST_HOLD;
              if (gc_q) begin
                raise_code = SC_GC_W;
              end else begin
                raise_code = arb_q ? SC_ARB_W : SC_OWN_W;
                arb_n      = 1'b0;
              end
            end
          end
          ST_DATA: begin
            if (scl_rise && !full) begin
              sh_n  = byte_in;
              cnt_n = cnt_q + CW'(1);
            end else if (scl_fall && full) begin
              state_n = ST_DACK;
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              raise       = 1'b1;
              raise_latch = 1'b1;
              nack_n      = !ack_next_q;
              state_n     = ST_HOLD;
              if (gc_q) raise_code = ack_next_q ? SC_GC_ACK  : SC_GC_NACK;
              else      raise_code = ack_next_q ? SC_OWN_ACK : SC_OWN_NACK;
            end
          end
          ST_HOLD: begin
            if (clr_pulse) begin
              cnt_n      = '0;
              ack_next_n = ack_at_clr;
              state_n    = nack_q ? ST_IDLE : ST_DATA;
            end
          end
          default: state_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      match_q    <= 1'b0;
      gc_q       <= 1'b0;
      ack_next_q <= 1'b0;
      nack_q     <= 1'b0;
      arb_q      <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      sh_q       <= sh_n;
      match_q    <= match_n;
      gc_q       <= gc_n;
      ack_next_q <= ack_next_n;
      nack_q     <= nack_n;
      arb_q      <= arb_n;
      hold_q     <= hold_n;
    end
  end

  always_comb begin
    rx_byte = sh_q;
    scl_low = hold_q;
    sda_low = en && ((state_q == ST_AACK) || ((state_q == ST_DACK) && ack_next_q));
  end

  // R8: no stretching unless the flag was pending on this or the previous cycle.
  a_r8_hold_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !$past(flag)) |-> !scl_low);

  // R10: a disabled block lets go of both lines.
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_low && !scl_low));

  // R7: one pending event at a time; no new report while the flag is up.
  a_r7_single_report: assert property (@(posedge clk) disable iff (!rst_n)
    raise |-> !flag);

endmodule

// File: rtl/tws_slave_rx.sv
module tws_slave_rx
  import tws_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              arb_lost_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic en, ack_en, gc_en, flag, clr_pulse, ack_at_clr;
  logic raise, raise_latch;
  logic [7:0]    raise_code;
  logic [DW-1:0] rx_byte;
  logic [DW-2:0] own_addr;

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_rx_engine #(.DW(DW)) u_engine (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en          (en),
    .ack_en      (ack_en),
    .own_addr    (own_addr),
    .gc_en       (gc_en),
    .arb_lost    (arb_lost_i),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .flag        (flag),
    .clr_pulse   (clr_pulse),
    .ack_at_clr  (ack_at_clr),
    .raise       (raise),
    .raise_code  (raise_code),
    .raise_latch (raise_latch),
    .rx_byte     (rx_byte),
    .sda_low     (sda_low_o),
    .scl_low     (scl_low_o)
  );

  tws_host_regs #(.DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (reg_wr_i),
    .addr        (reg_addr_i),
    .wdata       (reg_wdata_i),
    .raise       (raise),
    .raise_code  (raise_code),
    .raise_latch (raise_latch),
    .rx_byte     (rx_byte),
    .en          (en),
    .ack_en      (ack_en),
    .own_addr    (own_addr),
    .gc_en       (gc_en),
    .flag        (flag),
    .clr_pulse   (clr_pulse),
    .ack_at_clr  (ack_at_clr),
    .rdata       (reg_rdata_o)
  );

  assign irq_o = flag;

endmodule

// File: tb/tws_slave_rx_tb_top.sv
module tws_slave_rx_tb_top;

  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       arb_lost = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_low, sda_low, irq;
  logic       scl_line, sda_line;

  always #4 clk = ~clk;

  assign scl_line = m_scl & ~scl_low;
  assign sda_line = m_sda & ~sda_low;

  tws_slave_rx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_line),
    .sda_i       (sda_line),
    .scl_low_o   (scl_low),
    .sda_low_o   (sda_low),
    .arb_lost_i  (arb_lost),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  last_data = 8'h00;
  bit          mon_busy = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: record the event the bus action must produce.
  task automatic expect_ev(input logic [7:0] code, input logic [7:0] dat, input string tag);
    logic [7:0] d;
    d = (code == 8'hA0) ? last_data : dat;
    last_data = d;
    exp_q.push_back({code, d});
    tag_q.push_back(tag);
  endtask

  // Monitor: every flag rise is read through the host port and compared.
  initial begin
    logic [7:0] st, d1, d2;
    logic [15:0] e;
    string t;
    forever begin
      @(posedge irq);
      mon_busy = 1'b1;
      @(negedge clk);
      reg_addr = 2'd2;
      #1 st = reg_rdata;
      reg_addr = 2'd3;
      #1 d1 = reg_rdata;
      repeat (5) @(negedge clk);
      #1 d2 = reg_rdata;
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected flag", {st, d1}, 16'h0000);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(st == e[15:8], {t, " status"}, {8'h00, st}, {8'h00, e[15:8]});
        chk(d1 == e[7:0],  {t, " data"},   {8'h00, d1}, {8'h00, e[7:0]});
        chk(d2 == d1, "R11 data held while flag set", {8'h00, d2}, {8'h00, d1});
      end
      mon_busy = 1'b0;
    end
  end

  task automatic sync_mon();
    repeat (4) @(negedge clk);
    while (mon_busy) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Clear the flag; bit 6 of the same word selects ACK for the next byte.
  task automatic host_clear(input bit ack);
    sync_mon();
    host_wr(2'd0, {1'b1, ack, 5'b0, 1'b1});
  endtask

  task automatic put_bit(input bit b, output bit s);
    m_sda = b;
    repeat (H) @(negedge clk);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    repeat (H) @(negedge clk);
    s = sda_line;
    m_scl = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic bus_start();
    m_sda = 1'b1;
    repeat (H) @(negedge clk);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    repeat (H) @(negedge clk);
    m_sda = 1'b0;
    repeat (H) @(negedge clk);
    m_scl = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0;
    repeat (H) @(negedge clk);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    repeat (H) @(negedge clk);
    m_sda = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // Byte that must be ACKed and must raise the flag; checks the stretch and its release.
  task automatic byte_ok(input logic [7:0] b, input logic [7:0] code, input string tag);
    bit a;
    expect_ev(code, b, tag);
    send_byte(b, a);
    chk(a, {tag, " ack seen"}, {15'd0, a}, 16'd1);
    sync_mon();
    chk(scl_low == 1'b1, "R8 clock held while flag set", {15'd0, scl_low}, 16'd1);
  endtask

  task automatic byte_refused(input logic [7:0] b, input string tag);
    bit a;
    send_byte(b, a);
    chk(!a, {tag, " no ack"}, {15'd0, a}, 16'd0);
    repeat (4) @(negedge clk);
    chk(irq == 1'b0, {tag, " no flag"}, {15'd0, irq}, 16'd0);
  endtask

  task automatic clear_and_release(input bit ack);
    host_clear(ack);
    repeat (3) @(negedge clk);
    chk(scl_low == 1'b0, "R8 clock released after clear", {15'd0, scl_low}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    reg_addr = 2'd2;
    #1 chk(reg_rdata == 8'hF8, "R9 status after reset", {8'h0, reg_rdata}, 16'h00F8);
    chk(irq == 1'b0 && scl_low == 1'b0 && sda_low == 1'b0, "R9 idle outputs",
        {13'd0, irq, scl_low, sda_low}, 16'd0);

    // R10 disabled block ignores its own address
    host_wr(2'd1, 8'hA4);
    host_wr(2'd0, 8'h40);
    bus_start();
    byte_refused(8'hA4, "R10 disabled");
    bus_stop();

    host_wr(2'd0, 8'h41);

    // R1 own address, write direction
    bus_start();
    byte_ok(8'hA4, 8'h60, "R1 own address");
    clear_and_release(1'b1);

    // R6 data bytes; the same-cycle clear decides the next ACK
    byte_ok(8'h3C, 8'h80, "R6 acked byte");
    clear_and_release(1'b1);
    byte_ok(8'hC3, 8'h80, "R6 acked byte 2");
    clear_and_release(1'b0);
    begin
      bit a;
      expect_ev(8'h88, 8'h5A, "R6 refused byte");
      send_byte(8'h5A, a);
      chk(!a, "R6 NACK after clear with ack 0", {15'd0, a}, 16'd0);
    end
    sync_mon();
    host_clear(1'b1);
    byte_refused(8'h11, "R6 not addressed after NACK");
    bus_stop();
    repeat (4) @(negedge clk);
    reg_addr = 2'd2;
    #1 chk(reg_rdata == 8'hF8, "R9 status with flag clear", {8'h0, reg_rdata}, 16'h00F8);

    // R3 read direction and foreign address
    bus_start();
    byte_refused(8'hA5, "R3 read direction");
    bus_stop();
    bus_start();
    byte_refused(8'h20, "R3 foreign address");
    bus_stop();

    // R2 general call off, then on
    bus_start();
    byte_refused(8'h00, "R2 general call disabled");
    bus_stop();
    host_wr(2'd1, 8'hA5);
    bus_start();
    byte_ok(8'h00, 8'h70, "R2 general call");
    clear_and_release(1'b1);
    byte_ok(8'h77, 8'h90, "R6 general call ack");
    clear_and_release(1'b0);
    begin
      bit a;
      expect_ev(8'h98, 8'h88, "R6 general call nack");
      send_byte(8'h88, a);
      chk(!a, "R6 general call NACK", {15'd0, a}, 16'd0);
    end
    sync_mon();
    host_clear(1'b1);
    bus_stop();
    host_wr(2'd1, 8'hA4);

    // R4 acknowledge-enable low isolates, then recognition resumes
    host_wr(2'd0, 8'h01);
    bus_start();
    byte_refused(8'hA4, "R4 ack disabled");
    bus_stop();
    host_wr(2'd0, 8'h41);
    bus_start();
    byte_ok(8'hA4, 8'h60, "R4 resumed");
    clear_and_release(1'b1);
    // R7 STOP while addressed
    expect_ev(8'hA0, 8'h00, "R7 stop while addressed");
    bus_stop();
    sync_mon();
    host_clear(1'b1);

    // R7 repeated START while addressed
    bus_start();
    byte_ok(8'hA4, 8'h60, "R7 address");
    clear_and_release(1'b1);
    byte_ok(8'h12, 8'h80, "R7 data");
    clear_and_release(1'b1);
    expect_ev(8'hA0, 8'h00, "R7 repeated start");
    bus_start();
    sync_mon();
    host_clear(1'b1);
    byte_ok(8'hA4, 8'h60, "R7 address after repeated start");
    clear_and_release(1'b1);
    expect_ev(8'hA0, 8'h00, "R7 final stop");
    bus_stop();
    sync_mon();
    host_clear(1'b1);

    // R5 arbitration-lost strobe
    @(negedge clk);
    arb_lost = 1'b1;
    @(negedge clk);
    arb_lost = 1'b0;
    bus_start();
    byte_ok(8'hA4, 8'h68, "R5 after arbitration loss");
    clear_and_release(1'b1);
    expect_ev(8'hA0, 8'h00, "R7 stop after R5");
    bus_stop();
    sync_mon();
    host_clear(1'b1);
    bus_start();
    byte_ok(8'hA4, 8'h60, "R5 back to normal code");
    clear_and_release(1'b1);
    expect_ev(8'hA0, 8'h00, "R7 stop after R5 second");
    bus_stop();
    sync_mon();
    host_clear(1'b1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all expected events seen", 16'(exp_q.size()), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule